// File: doc/BRIEF.md
# Column-serial AES-128 block decryptor

This block turns one 128-bit AES-128 ciphertext block into its plaintext. It works on one 32-bit state column per clock. A pulse on `start` loads the ciphertext into a state bank. A sequencer then runs three kinds of round: a whitening pass, nine full inverse rounds and a final inverse round. Each round issues the four columns on consecutive cycles, and one extra cycle lets the two-stage column pipeline drain. Two state banks alternate as source and destination from round to round, so the write-back of one column never disturbs a byte that a later column of the same round still has to read.

The inverse row shift costs no logic of its own. It is folded into the read addressing: four 32-bit four-way multiplexers each pick a whole source column, and one byte of that column feeds one of four 256-entry inverse substitution tables. The substituted column is registered. In the next stage it is XORed with a round-key word, and in the nine middle rounds it is then passed through the inverse column mix. The result is written to the other bank.

Round keys are held outside the block in an already-expanded 44-word schedule. The core drives a word index and expects the addressed word back in the same cycle. It walks the schedule from the last round key down to the first.

Top module: `aes_dec_core`

## Requirements
- R1: The whitening pass XORs state column c of the ciphertext, with no substitution and no mixing, with schedule word 40+c. These are the four words of the last round key.
- R2: For the FIPS-197 test vectors, and for the all-zero key with the all-zero block, `plaintext` equals the published plaintext when `done` is raised. Each middle round does inverse substitution with the row shift undone, then the key XOR, then inverse mixing by rows {0E 0B 0D 09}, {09 0E 0B 0D}, {0D 09 0E 0B}, {0B 0D 09 0E}. The last round does not mix.
- R3: In the issue cycle of column c of round k (round 0 is the whitening pass, rounds 1 to 10 are inverse rounds), `key_idx` equals 4*(10-k)+c. `key_word` is taken combinationally in that same cycle.
- R4: Block layout: column c occupies bits [127-32c -: 32]. Row r of a column is byte r, counted from the most significant byte. Schedule word i of round key j is word 4j+i, in the same byte order. Output column c, row r is taken from input column (c-r) mod 4.
- R5: `done` is high for exactly one cycle: the 55th rising edge after the edge that accepts `start`. `plaintext` is complete from that edge and holds its value until the next completion.
- R6: `start` is ignored while a block is being processed. The running block's result and its single `done` pulse are unaffected.
- R7: Synchronous active-high `rst` clears `done` and `plaintext` and abandons any block in progress, so that no `done` follows.
- R8: A `start` presented in the cycle where `done` is high is accepted, so blocks can follow each other with no gap beyond the idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decrypting `ciphertext`; sampled only when idle |
| ciphertext | input | 128 | Block to decrypt, sampled on the accepting edge |
| key_idx | output | 6 | Index of the expanded-schedule word wanted this cycle |
| key_word | input | 32 | Schedule word at `key_idx`, same cycle |
| plaintext | output | 128 | Registered result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle, the cycle-level rules of the sequencer: `done` is a single-cycle pulse that only follows a run; the plaintext register stays frozen whenever no run is active; and within a round the column counter and the schedule index each step by exactly one. Only the bench's scenarios can show that the composite transform is correct. This covers the multiplexer byte routing, the table contents, the placement of the key XOR ahead of the mix, and the skipped mix in the last round, all through the known-answer vectors. The bench scenarios also cover the absolute latency and the handling of `start` mid-run, back-to-back and under reset.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;

  localparam int unsigned COLS   = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = COLS * BYTE_W;
  localparam int unsigned BLK_W  = COLS * WORD_W;
  localparam int unsigned COL_W  = $clog2(COLS);

  typedef enum logic [1:0] {
    K_PRE  = 2'd0,
    K_MID  = 2'd1,
    K_LAST = 2'd2
  } step_kind_t;

  typedef struct packed {
    logic              vld;
    step_kind_t        kind;
    logic [COL_W-1:0]  col;
    logic [WORD_W-1:0] dat;
    logic [WORD_W-1:0] key;
  } col_stage_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xt(sh);
    end
    return acc;
  endfunction

  // a^254 by square-and-multiply; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (i != 0) r = gf_mul(r, a);
    end
    return r;
  endfunction

  function automatic logic [7:0] inv_sub_val(input logic [7:0] s);
    logic [7:0] t;
    t = {s[6:0], s[7]} ^ {s[4:0], s[7:5]} ^ {s[1:0], s[7:2]} ^ 8'h05;
    return gf_inv(t);
  endfunction

  function automatic logic [7:0] m09(input logic [7:0] a);
    logic [7:0] a8;
    a8 = xt(xt(xt(a)));
    return a8 ^ a;
  endfunction

  function automatic logic [7:0] m0b(input logic [7:0] a);
    logic [7:0] a2;
    a2 = xt(a);
    return xt(xt(a2)) ^ a2 ^ a;
  endfunction

  function automatic logic [7:0] m0d(input logic [7:0] a);
    logic [7:0] a4;
    a4 = xt(xt(a));
    return xt(a4) ^ a4 ^ a;
  endfunction

  function automatic logic [7:0] m0e(input logic [7:0] a);
    logic [7:0] a2;
    logic [7:0] a4;
    a2 = xt(a);
    a4 = xt(a2);
    return xt(a4) ^ a4 ^ a2;
  endfunction

endpackage

// File: rtl/aes_isub_rom.sv
module aes_isub_rom #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] table_q [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      table_q[i] = DW'(aes_dec_pkg::inv_sub_val(8'(i)));
    end
  end

  assign data = table_q[addr];
endmodule

// File: rtl/aes_col_fetch.sv
module aes_col_fetch
  import aes_dec_pkg::*;
(
  input  logic [0:COLS-1][WORD_W-1:0] bank,
  input  logic [COL_W-1:0]            col,
  input  logic                        bypass,
  output logic [WORD_W-1:0]           word
);
  logic [BYTE_W-1:0] out_b [COLS];

  for (genvar r = 0; r < COLS; r++) begin : g_row
    logic [COL_W-1:0]  src;
    logic [WORD_W-1:0] pick;
    logic [BYTE_W-1:0] raw;
    logic [BYTE_W-1:0] sub;

    // row r of output column col comes from column (col - r) mod COLS
    assign src  = col - COL_W'(r);
    assign pick = bank[src];
    assign raw  = pick[WORD_W-1-BYTE_W*r -: BYTE_W];

    aes_isub_rom #(.AW(BYTE_W), .DW(BYTE_W)) u_rom (
      .addr (raw),
      .data (sub)
    );

    assign out_b[r] = bypass ? bank[col][WORD_W-1-BYTE_W*r -: BYTE_W] : sub;
  end

  always_comb begin
    for (int r = 0; r < COLS; r++) begin
      word[WORD_W-1-BYTE_W*r -: BYTE_W] = out_b[r];
    end
  end
endmodule

// File: rtl/aes_inv_mix.sv
module aes_inv_mix
  import aes_dec_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  logic [7:0] a0, a1, a2, a3;

  assign {a0, a1, a2, a3} = din;

  assign dout = {
    m0e(a0) ^ m0b(a1) ^ m0d(a2) ^ m09(a3),
    m09(a0) ^ m0e(a1) ^ m0b(a2) ^ m0d(a3),
    m0d(a0) ^ m09(a1) ^ m0e(a2) ^ m0b(a3),
    m0b(a0) ^ m0d(a1) ^ m09(a2) ^ m0e(a3)
  };
endmodule

// File: rtl/aes_dec_ctrl.sv
module aes_dec_ctrl
  import aes_dec_pkg::*;
#(
  parameter int unsigned NR = 10,
  localparam int unsigned KW = $clog2((NR + 1) * COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             load,
  output logic             issue,
  output logic             round_end,
  output logic [COL_W-1:0] col,
  output step_kind_t       kind,
  output logic [KW-1:0]    key_idx
);
  localparam int unsigned RW = $clog2(NR + 1);
  localparam int unsigned CW = $clog2(COLS + 1);

  logic          running;
  logic [RW-1:0] rnd;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      rnd     <= '0;
      cyc     <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        rnd     <= '0;
        cyc     <= '0;
      end
    end else if (cyc == CW'(COLS)) begin
      cyc <= '0;
      if (rnd == RW'(NR)) running <= 1'b0;
      else                rnd     <= rnd + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  assign busy      = running;
  assign load      = !running && start;
  assign issue     = running && (cyc < CW'(COLS));
  assign round_end = running && (cyc == CW'(COLS));
  assign col       = cyc[COL_W-1:0];

  always_comb begin
    if (rnd == '0)           kind = K_PRE;
    else if (rnd == RW'(NR)) kind = K_LAST;
    else                     kind = K_MID;
  end

  // schedule walked from the last round key back to the first
  assign key_idx = KW'((int'(NR) - int'(rnd)) * int'(COLS) + int'(col));
endmodule

// File: rtl/aes_dec_core.sv
module aes_dec_core
  import aes_dec_pkg::*;
#(
  parameter int unsigned NR = 10,
  localparam int unsigned KW = $clog2((NR + 1) * COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BLK_W-1:0]  ciphertext,
  output logic [KW-1:0]     key_idx,
  input  logic [WORD_W-1:0] key_word,
  output logic [BLK_W-1:0]  plaintext,
  output logic              done
);
  logic [0:COLS-1][WORD_W-1:0] bank [2];
  logic [0:COLS-1][WORD_W-1:0] pt_q;
  logic                        rd_sel;

  logic             busy, load, issue, round_end;
  logic [COL_W-1:0] col;
  step_kind_t       kind;

  logic [WORD_W-1:0] fetched;
  logic [WORD_W-1:0] keyed;
  logic [WORD_W-1:0] mixed;
  logic [WORD_W-1:0] result;
  col_stage_t        s1;
  logic              done_q;

  aes_dec_ctrl #(.NR(NR)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .load      (load),
    .issue     (issue),
    .round_end (round_end),
    .col       (col),
    .kind      (kind),
    .key_idx   (key_idx)
  );

  aes_col_fetch u_fetch (
    .bank   (bank[rd_sel]),
    .col    (col),
    .bypass (kind == K_PRE),
    .word   (fetched)
  );

  // stage 1: substituted column plus its key word
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
    end else begin
      s1.vld  <= issue;
      s1.kind <= kind;
      s1.col  <= col;
      s1.dat  <= fetched;
      s1.key  <= key_word;
    end
  end

  // stage 2: key XOR, then inverse mixing in the middle rounds
  assign keyed = s1.dat ^ s1.key;

  aes_inv_mix u_mix (
    .din  (keyed),
    .dout (mixed)
  );

  assign result = (s1.kind == K_MID) ? mixed : keyed;

  always_ff @(posedge clk) begin
    if (load) bank[rd_sel] <= ciphertext;
    if (s1.vld) bank[!rd_sel][s1.col] <= result;
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_sel <= 1'b0;
    else if (round_end) rd_sel <= !rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (s1.vld && s1.kind == K_LAST) pt_q[s1.col] <= keyed;
      done_q <= s1.vld && (s1.kind == K_LAST) && (s1.col == COL_W'(COLS - 1));
    end
  end

  assign plaintext = pt_q;
  assign done      = done_q;
endmodule

// File: rtl/aes_dec_chk.sv
module aes_dec_chk
  import aes_dec_pkg::*;
#(
  parameter int unsigned NR = 10,
  localparam int unsigned KW = $clog2((NR + 1) * COLS)
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             issue,
  input logic [COL_W-1:0] col,
  input logic [KW-1:0]    key_idx,
  input logic [BLK_W-1:0] plaintext,
  input logic             done
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_run_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  p_pt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(plaintext));

  p_key_step_r3: assert property (@(posedge clk) disable iff (rst)
    (issue && col != '0) |-> (key_idx == $past(key_idx) + KW'(1)));

  p_key_range_r3: assert property (@(posedge clk) disable iff (rst)
    issue |-> (key_idx < KW'((NR + 1) * COLS)));

  p_col_step_r6: assert property (@(posedge clk) disable iff (rst)
    (issue && col != COL_W'(COLS - 1)) |=> (issue && col == $past(col) + COL_W'(1)));
endmodule

bind aes_dec_core aes_dec_chk #(.NR(NR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .issue     (issue),
  .col       (col),
  .key_idx   (key_idx),
  .plaintext (plaintext),
  .done      (done)
);

// File: tb/sim_aes_dec_core.sv
`timescale 1ns/1ps
module sim_aes_dec_core;
  localparam int LAT = 55;
  localparam int NV  = 3;
  // each entry: {key, ciphertext, plaintext}
  localparam logic [383:0] VEC [NV] = '{
    {128'h000102030405060708090a0b0c0d0e0f,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a,
     128'h00112233445566778899aabbccddeeff},
    {128'h2b7e151628aed2a6abf7158809cf4f3c,
     128'h3925841d02dc09fbdc118597196a0b32,
     128'h3243f6a8885a308d313198a2e0370734},
    {128'h0,
     128'h66e94bd4ef8a2c3b884cfa59ca342b2e,
     128'h0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] ct_in = '0;
  logic [5:0]   key_idx;
  logic [31:0]  key_word;
  logic [127:0] plaintext;
  logic         done;
  logic [31:0]  ks [44];
  int           checks = 0;
  int           fails = 0;

  always #4 clk = ~clk;

  assign key_word = (key_idx < 6'd44) ? ks[key_idx] : 32'h0;

  aes_dec_core u0 (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ciphertext (ct_in),
    .key_idx    (key_idx),
    .key_word   (key_word),
    .plaintext  (plaintext),
    .done       (done)
  );

  function automatic logic [7:0] b_xt(input logic [7:0] a);
    return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = b_xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] b_sbox(input logic [7:0] x);
    logic [7:0] v = 8'h00;
    for (int y = 1; y < 256; y++) if (b_mul(x, 8'(y)) == 8'h01) v = 8'(y);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  task automatic expand(input logic [127:0] k);
    logic [7:0]  rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < 4; i++) ks[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = ks[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {b_sbox(t[31:24]), b_sbox(t[23:16]), b_sbox(t[15:8]), b_sbox(t[7:0])};
        t = t ^ {rc, 24'h0};
        rc = b_xt(rc);
      end
      ks[i] = ks[i-4] ^ t;
    end
  endtask

  task automatic chk(input bit ok, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // called at a negedge; returns at the negedge after the expected done edge
  task automatic run_block(input logic [127:0] ctv, input logic [127:0] ptv,
                           input int bump, input logic [127:0] bump_ct);
    int ndone = 0;
    ct_in = ctv;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(key_idx == 6'd40, "R1 whitening column 0 key index", 128'(key_idx), 128'd40);
    for (int n = 1; n <= LAT; n++) begin
      if (n == bump) begin start = 1'b1; ct_in = bump_ct; end
      if (n == bump + 1) start = 1'b0;
      @(negedge clk);
      if (done) ndone++;
      if (n == 1)  chk(key_idx == 6'd41, "R3 key index round 0 col 1", 128'(key_idx), 128'd41);
      if (n == 5)  chk(key_idx == 6'd36, "R3 key index round 1 col 0", 128'(key_idx), 128'd36);
      if (n == 53) chk(key_idx == 6'd3,  "R3 key index round 10 col 3", 128'(key_idx), 128'd3);
      if (n == LAT - 1) chk(done == 1'b0, "R5 done early", 128'(done), 128'd0);
      if (n == LAT) begin
        chk(done == 1'b1, "R5 done at latency", 128'(done), 128'd1);
        chk(plaintext == ptv, "R2 R4 plaintext", plaintext, ptv);
      end
    end
    start = 1'b0;
    chk(ndone == 1, "R6 single done pulse", 128'(ndone), 128'd1);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R7 reset done", 128'(done), 128'd0);
    chk(plaintext == '0, "R7 reset plaintext", plaintext, 128'd0);
    rst = 1'b0;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      expand(VEC[v][383:256]);
      run_block(VEC[v][255:128], VEC[v][127:0], -5, '0);
      repeat (2) @(negedge clk);
    end

    // R5: result holds while idle
    repeat (8) @(negedge clk);
    chk(done == 1'b0, "R5 no extra done", 128'(done), 128'd0);
    chk(plaintext == VEC[NV-1][127:0], "R5 plaintext held", plaintext, VEC[NV-1][127:0]);

    // R6: start with another ciphertext in the middle of a run
    expand(VEC[1][383:256]);
    run_block(VEC[1][255:128], VEC[1][127:0], 20, VEC[0][255:128]);

    // R8: back-to-back, new start in the done cycle
    run_block(VEC[1][255:128], VEC[1][127:0], -5, '0);
    run_block(VEC[1][255:128], VEC[1][127:0], -5, '0);

    // R7: reset in the middle of a run
    @(negedge clk);
    expand(VEC[0][383:256]);
    ct_in = VEC[0][255:128];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    begin
      int seen = 0;
      for (int n = 0; n < 70; n++) begin
        @(negedge clk);
        if (done) seen++;
      end
      chk(seen == 0, "R7 no done after reset", 128'(seen), 128'd0);
    end
    chk(plaintext == '0, "R7 plaintext cleared", plaintext, 128'd0);

    // after reset the core still decrypts
    run_block(VEC[0][255:128], VEC[0][127:0], -5, '0);
    report();
  end
endmodule